// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Front End

This block is a synthesizable model of a double-data-rate static memory with a dedicated write data input and a dedicated read data output. Both ports share one address bus. Each address holds a pair of words, and every access moves both words of the pair. The design runs on a single clock whose cycles stand for the two halves of one memory clock period. An internal phase bit marks the cycles that end on the rising K edge and those that end on the rising K# edge. Transactions are only accepted on K edges, and data beats move on both edges.

A host starts an access by pulling the active-low load strobe low for a K edge, with a direction select and an address. A write then delivers its first word with that K edge and its second word with the following K# edge. Each beat carries its own active-low lane write selects. A read returns its two words a fixed 1.5 memory periods later, qualified by a valid flag. Reads and writes may follow each other on every K edge, so a read can be in flight while a write completes. A read issued after a write to the same address sees the new data, which is forwarded from the write registers if the array has not yet been updated.

Top module: `dual_beat_sram`

## Requirements
- R1: While reset is held and in the first cycle after its release, rvalid is 0, rdata is all zeros and beat_phase is 0.
- R2: beat_phase alternates every clock cycle. A cycle with beat_phase 0 ends on a K edge, and a cycle with beat_phase 1 ends on a K# edge.
- R3: A transaction starts only when ld_n is 0 at a K edge. When ld_n is 1 at a K edge, addr, rd_sel, wdata and bw_n are ignored: nothing is stored and no read data is returned.
- R4: A read (ld_n 0, rd_sel 1 at a K edge, cycle c) drives word 0 of the addressed pair on rdata in cycle c+4 and word 1 in cycle c+5.
- R5: rvalid is 1 exactly in the cycles that carry read words. Whenever rvalid is 0, rdata is all zeros.
- R6: A write (ld_n 0, rd_sel 0 at a K edge) stores wdata from that K edge as word 0 and wdata from the following K# edge as word 1 of the addressed pair.
- R7: bw_n has one active-low select per lane. Lane i covers wdata bits [i*W +: W], with W = DATA_W/LANES. Each beat uses the bw_n sampled with that beat. A lane whose select is 1 keeps its previous stored value.
- R8: A read captured on any K edge after a write's capture edge returns that write's data, including a read on the very next K edge.
- R9: Reads on consecutive K edges produce an unbroken stream with rvalid held high and the words in issue order.
- R10: Reset cancels work in flight. A write whose commit has not happened stores nothing, and a read whose words have not appeared produces none.
- R11: ld_n, rd_sel, addr and wdata presented for a K# edge cannot start a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period clock; each edge is alternately a K or K# edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_phase | output | 1 | 0 when the next edge is K, 1 when it is K# |
| ld_n | input | 1 | Active-low load strobe, sampled on K edges |
| rd_sel | input | 1 | 1 selects a read, 0 a write, when loading |
| addr | input | ADDR_W | Shared address of the word pair |
| bw_n | input | LANES | Active-low lane write selects, per beat |
| wdata | input | DATA_W | Write data beat |
| rdata | output | DATA_W | Read data beat, zero when not valid |
| rvalid | output | 1 | Read data output enable |

## Verification
Corrupted write capture or commit state does not show up at once. It appears only when the affected address is next read, four cycles after that read's K edge, as a wrong lane in one of the two words. The bench therefore reads every address back after each sweep. A phase or read pipeline fault is visible sooner. rvalid rises on the wrong cycle, drops between streamed reads, or rdata is nonzero while idle, and this is caught in the very cycle it occurs. Cancelled transactions are checked by reading their addresses after reset, where any stray commit shows as new data.

// File: rtl/dbsram_pkg.sv
`timescale 1ns/1ps
package dbsram_pkg;
   // Which edge closes the current cycle.
   typedef enum logic {
      PH_K  = 1'b0,
      PH_KB = 1'b1
   } beat_ph_e;
endpackage

// File: rtl/dbsram_merge.sv
`timescale 1ns/1ps
module dbsram_merge #(
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] new_i,
   input  logic [LANES-1:0]  en_i,
   output logic [DATA_W-1:0] out_o
);
   localparam int LW = DATA_W / LANES;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign out_o[l*LW +: LW] = en_i[l] ? new_i[l*LW +: LW] : old_i[l*LW +: LW];
   end
endmodule

// File: rtl/dbsram_wr_path.sv
`timescale 1ns/1ps
module dbsram_wr_path
   import dbsram_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_ph_e          ph,
   input  logic              ld_n,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  bw_n,
   output logic              cm_en,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [DATA_W-1:0] cm_d0,
   output logic [DATA_W-1:0] cm_d1,
   output logic [LANES-1:0]  cm_m0,
   output logic [LANES-1:0]  cm_m1
);
   logic              wr_start;
   logic              b0_pend_q;
   logic              commit_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] d0_q, d1_q;
   logic [LANES-1:0]  m0_q, m1_q;

   assign wr_start = (ph == PH_K) && !ld_n && !rd_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b0_pend_q <= 1'b0;
         commit_q  <= 1'b0;
      end else if (ph == PH_K) begin
         b0_pend_q <= wr_start;
         commit_q  <= 1'b0;
      end else begin
         b0_pend_q <= 1'b0;
         commit_q  <= b0_pend_q;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_start) begin
         addr_q <= addr;
         d0_q   <= wdata;
         m0_q   <= ~bw_n;
      end
      if ((ph == PH_KB) && b0_pend_q) begin
         d1_q <= wdata;
         m1_q <= ~bw_n;
      end
   end

   assign cm_en   = commit_q;
   assign cm_addr = addr_q;
   assign cm_d0   = d0_q;
   assign cm_d1   = d1_q;
   assign cm_m0   = m0_q;
   assign cm_m1   = m1_q;
endmodule

// File: rtl/dbsram_array.sv
`timescale 1ns/1ps
module dbsram_array #(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wd0,
   input  logic [DATA_W-1:0] wd1,
   input  logic [LANES-1:0]  wm0,
   input  logic [LANES-1:0]  wm1,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rd0,
   output logic [DATA_W-1:0] rd1
);
   localparam int LW    = DATA_W / LANES;
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] bank0 [DEPTH];
      logic [LW-1:0] bank1 [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wm0[l]) bank0[waddr] <= wd0[l*LW +: LW];
         if (we && wm1[l]) bank1[waddr] <= wd1[l*LW +: LW];
      end

      assign rd0[l*LW +: LW] = bank0[raddr];
      assign rd1[l*LW +: LW] = bank1[raddr];
   end
endmodule

// File: rtl/dbsram_rd_path.sv
`timescale 1ns/1ps
module dbsram_rd_path
   import dbsram_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_ph_e          ph,
   input  logic              ld_n,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] arr0,
   input  logic [DATA_W-1:0] arr1,
   input  logic              cm_en,
   input  logic [ADDR_W-1:0] cm_addr,
   input  logic [DATA_W-1:0] cm_d0,
   input  logic [DATA_W-1:0] cm_d1,
   input  logic [LANES-1:0]  cm_m0,
   input  logic [LANES-1:0]  cm_m1,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic              rd_start;
   logic              hit;
   logic [LANES-1:0]  f_m0, f_m1;
   logic [DATA_W-1:0] fw0, fw1;
   logic              sa_v_q, sb_v_q, tail_q, rvalid_q;
   logic [DATA_W-1:0] sa0_q, sa1_q, sb0_q, sb1_q, rdata_q;

   assign rd_start = (ph == PH_K) && !ld_n && rd_sel;
   assign hit      = cm_en && (cm_addr == addr);
   assign f_m0     = hit ? cm_m0 : '0;
   assign f_m1     = hit ? cm_m1 : '0;

   dbsram_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_fwd0 (
      .old_i(arr0), .new_i(cm_d0), .en_i(f_m0), .out_o(fw0));
   dbsram_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_fwd1 (
      .old_i(arr1), .new_i(cm_d1), .en_i(f_m1), .out_o(fw1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_v_q   <= 1'b0;
         sb_v_q   <= 1'b0;
         tail_q   <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (ph == PH_K) begin
         sa_v_q <= rd_start;
         sb_v_q <= sa_v_q;
         tail_q <= 1'b0;
         if (tail_q) begin
            rdata_q  <= sb1_q;
            rvalid_q <= 1'b1;
         end else begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
         end
      end else begin
         if (sb_v_q) begin
            rdata_q  <= sb0_q;
            rvalid_q <= 1'b1;
            tail_q   <= 1'b1;
         end else begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rd_start) begin
         sa0_q <= fw0;
         sa1_q <= fw1;
      end
      if (ph == PH_K) begin
         sb0_q <= sa0_q;
         sb1_q <= sa1_q;
      end
   end

   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;
endmodule

// File: rtl/dual_beat_sram.sv
`timescale 1ns/1ps
module dual_beat_sram
   import dbsram_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              beat_phase,
   input  logic              ld_n,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   beat_ph_e          ph_q;
   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [DATA_W-1:0] cm_d0, cm_d1, arr0, arr1;
   logic [LANES-1:0]  cm_m0, cm_m1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_K;
      else        ph_q <= (ph_q == PH_K) ? PH_KB : PH_K;
   end
   assign beat_phase = ph_q;

   dbsram_wr_path #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .ph(ph_q), .ld_n(ld_n), .rd_sel(rd_sel),
      .addr(addr), .wdata(wdata), .bw_n(bw_n),
      .cm_en(cm_en), .cm_addr(cm_addr), .cm_d0(cm_d0), .cm_d1(cm_d1),
      .cm_m0(cm_m0), .cm_m1(cm_m1));

   dbsram_array #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
      .clk(clk), .we(cm_en), .waddr(cm_addr), .wd0(cm_d0), .wd1(cm_d1),
      .wm0(cm_m0), .wm1(cm_m1), .raddr(addr), .rd0(arr0), .rd1(arr1));

   dbsram_rd_path #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .ph(ph_q), .ld_n(ld_n), .rd_sel(rd_sel),
      .addr(addr), .arr0(arr0), .arr1(arr1),
      .cm_en(cm_en), .cm_addr(cm_addr), .cm_d0(cm_d0), .cm_d1(cm_d1),
      .cm_m0(cm_m0), .cm_m1(cm_m1),
      .rdata(rdata), .rvalid(rvalid));
endmodule

// File: rtl/dbsram_chk.sv
`timescale 1ns/1ps
module dbsram_chk #(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              beat_phase,
   input logic              ld_n,
   input logic              rd_sel,
   input logic              rvalid,
   input logic [DATA_W-1:0] rdata,
   input logic              cm_en
);
   logic up_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_q <= 1'b0;
      else        up_q <= 1'b1;
   end

   // R2
   ph_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_q |-> (beat_phase != $past(beat_phase)));

   // R5
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));

   // R4
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> (beat_phase == 1'b0));

   // R5
   two_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);

   // R3
   read_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> $past(!ld_n && rd_sel && (beat_phase == 1'b0), 4));

   // R6
   commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_en |-> ((beat_phase == 1'b0) && $past(!ld_n && !rd_sel && (beat_phase == 1'b0), 2)));
endmodule

bind dual_beat_sram dbsram_chk #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .beat_phase(beat_phase), .ld_n(ld_n),
   .rd_sel(rd_sel), .rvalid(rvalid), .rdata(rdata), .cm_en(cm_en));

// File: tb/dual_beat_sram_bench.sv
`timescale 1ns/1ps
module dual_beat_sram_bench;
   localparam int DW = 18;
   localparam int NL = 2;
   localparam int AW = 4;
   localparam int LW = DW / NL;
   localparam int NA = 1 << AW;
   localparam int NX = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          beat_phase;
   logic          ld_n = 1'b1;
   logic          rd_sel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NL-1:0] bw_n = '1;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   logic [DW-1:0] mdl [NA][2];
   bit            exp_v [NX];
   logic [DW-1:0] exp_d [NX];
   int            exp_r [NX];

   dual_beat_sram #(.DATA_W(DW), .LANES(NL), .ADDR_W(AW)) u_dual_beat_sram (
      .clk(clk), .rst_n(rst_n), .beat_phase(beat_phase), .ld_n(ld_n),
      .rd_sel(rd_sel), .addr(addr), .bw_n(bw_n), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid));

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] pat(input int a, input int b, input int k);
      return DW'((a * 7919 + b * 131 + k * 977 + 3) ^ (a << 9) ^ (k << 13));
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // R4 R5 R9: every cycle, rvalid and rdata against the schedule built at issue time
   always @(negedge clk) begin
      if (mon_on && rst_n && cyc < NX) begin
         if (exp_v[cyc]) begin
            chk(rvalid === 1'b1, "R5 rvalid missing", DW'(rvalid), DW'(1));
            chk(rdata === exp_d[cyc], $sformatf("R%0d read word", exp_r[cyc]), rdata, exp_d[cyc]);
         end else begin
            chk(rvalid === 1'b0, "R5 rvalid stray", DW'(rvalid), DW'(0));
            chk(rdata === '0, "R5 idle rdata", rdata, '0);
         end
      end
   end

   // One K period: K-half transaction, then K#-half beat (with optional load on K#, R11).
   task automatic kper(input bit ld, input bit rd, input int a,
                       input logic [DW-1:0] d0, input logic [NL-1:0] m0n,
                       input logic [DW-1:0] d1, input logic [NL-1:0] m1n,
                       input int tag, input bit kb_ld, input bit kb_rd, input int kb_a);
      chk(beat_phase === 1'b0, "R2 K half phase", DW'(beat_phase), DW'(0));
      ld_n = !ld; rd_sel = rd; addr = AW'(a); wdata = d0; bw_n = m0n;
      if (ld && !rd) begin
         for (int l = 0; l < NL; l++) begin
            if (!m0n[l]) mdl[a][0][l*LW +: LW] = d0[l*LW +: LW];
            if (!m1n[l]) mdl[a][1][l*LW +: LW] = d1[l*LW +: LW];
         end
      end
      if (ld && rd && cyc + 5 < NX) begin
         exp_v[cyc+4] = 1'b1; exp_d[cyc+4] = mdl[a][0]; exp_r[cyc+4] = tag;
         exp_v[cyc+5] = 1'b1; exp_d[cyc+5] = mdl[a][1]; exp_r[cyc+5] = tag;
      end
      @(posedge clk); #1;
      chk(beat_phase === 1'b1, "R2 K# half phase", DW'(beat_phase), DW'(1));
      ld_n = !kb_ld; rd_sel = kb_rd; addr = AW'(kb_a); wdata = d1; bw_n = m1n;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) kper(0, 0, 0, '0, '1, '0, '1, 5, 0, 0, 0);
   endtask

   task automatic rd(input int a, input int tag);
      kper(1, 1, a, '0, '1, '0, '1, tag, 0, 0, 0);
   endtask

   task automatic read_all(input int tag);
      for (int a = 0; a < NA; a++) rd(a, tag);
      idle(3);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ld_n = 1'b1;
      for (int i = cyc; i < NX; i++) exp_v[i] = 1'b0;
      @(posedge clk); #1;
      // R1: state while reset is held
      chk(rvalid === 1'b0, "R1 rvalid in reset", DW'(rvalid), DW'(0));
      chk(rdata === '0, "R1 rdata in reset", rdata, '0);
      chk(beat_phase === 1'b0, "R1 phase in reset", DW'(beat_phase), DW'(0));
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(rvalid === 1'b0 && rdata === '0, "R1 outputs after release", rdata, '0);
      chk(beat_phase === 1'b0, "R1 phase after release", DW'(beat_phase), DW'(0));
      @(posedge clk); #1;
      chk(beat_phase === 1'b1, "R2 first toggle", DW'(beat_phase), DW'(1));
      @(posedge clk); #1;
   endtask

   initial begin
      for (int i = 0; i < NX; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_r[i] = 5; end
      #1;
      do_reset();
      mon_on = 1'b1;

      // R6: fill every pair with full-lane writes
      for (int a = 0; a < NA; a++)
         kper(1, 0, a, pat(a, 0, 1), '0, pat(a, 1, 1), '0, 6, 0, 0, 0);
      idle(1);
      // R4 R9: back-to-back read sweep
      read_all(9);

      // R7 R8: every mask pair across beats, each followed by a read on the next K edge
      for (int a = 0; a < NA; a++) begin
         kper(1, 0, a, pat(a, 0, 2), NL'(a & 3), pat(a, 1, 2), NL'((a >> 2) & 3), 7, 0, 0, 0);
         rd(a, 8);
      end
      idle(3);
      read_all(7);

      // R3: deselected K edges with live-looking inputs
      for (int a = 0; a < NA; a++)
         kper(0, a & 1, a, pat(a, 0, 3), '0, pat(a, 1, 3), '0, 3, 0, 0, 0);
      idle(3);
      read_all(3);

      // R11: load attempts on K# edges, both directions
      for (int a = 0; a < NA; a++)
         kper(0, 0, 0, pat(a, 0, 4), '0, pat(a, 1, 4), '0, 11, 1, a & 1, a);
      idle(3);
      read_all(11);

      // R4: isolated reads with gaps
      for (int a = 0; a < 4; a++) begin rd(a * 5 % NA, 4); idle(2); end

      // R10: reset during write second beat
      chk(beat_phase === 1'b0, "R2 K half phase", DW'(beat_phase), DW'(0));
      ld_n = 1'b0; rd_sel = 1'b0; addr = AW'(3); wdata = pat(3, 0, 5); bw_n = '0;
      @(posedge clk); #1;
      wdata = pat(3, 1, 5); ld_n = 1'b1;
      do_reset();
      // R10: reset while the write waits for its commit edge (model untouched)
      ld_n = 1'b0; rd_sel = 1'b0; addr = AW'(4); wdata = pat(4, 0, 6); bw_n = '0;
      @(posedge clk); #1;
      ld_n = 1'b1; wdata = pat(4, 1, 6);
      @(posedge clk); #1;
      do_reset();
      // R10: reset with a read in flight
      rd(5, 10);
      do_reset();
      idle(3);
      rd(3, 10); rd(4, 10); rd(5, 10);
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule